// File: doc/BRIEF.md
# Serial flag offset loader

This block holds the two threshold values that a FIFO's almost-empty and almost-full flag logic compares against, and lets them be loaded one bit at a time over a serial port. A bit on the serial data line is taken on a rising serial-clock edge when both active-low control lines (load select and serial enable) are low. A single 30-bit stream fills both 15-bit offsets. The first 15 bits go into the empty offset, least significant bit first, and the last 15 go into the full offset, ending with its most significant bit. Either offset alone cannot be rewritten: any change means the whole stream is shifted in again.

Loading may stop partway and start again later. Raising either control line stops it, and the block keeps its place in the stream. Each offset has a validity indication, and the flag logic may use that offset only while the indication is high. The first captured bit of a stream clears both indications. They come back only after the last bit has landed. Each indication is raised by its own clock domain: the almost-full validity by the write clock and the almost-empty validity by the read clock, each three rising edges of that clock after the completing serial edge.

A master reset puts the offsets at their default values and clears both indications. Once reset is released, the defaults count as a complete load and the indications rise after the same three-edge delay.

Top module: `serial_offset_loader`

## Requirements
- R1: While `rst_n` is low on rising clock edges, both offsets read 7 and both validity outputs are low. When that clock domain has the same clocks, each validity output goes high at the third rising edge after the first edge with `rst_n` high.
- R2: A serial bit is written only on a rising `sclk` edge where `load_n` and `sen_n` are both sampled low. On any other edge both offsets keep their values.
- R3: Stream bit k (k = 0..14, counted from the start of a stream) is written to `empty_ofs[k]`. Stream bit 15+k is written to `full_ofs[k]`. Every stream is 30 bits long.
- R4: With `load_n` low and `sen_n` high, no bit is written and the stream position does not advance.
- R5: With `load_n` high, no bit is written whatever `sen_n` is. Once both lines are low again, loading resumes at the next bit in the stream.
- R6: The first bit of a stream makes both validity outputs low by the third rising edge of their clocks. They stay low until the 30th bit has been captured, including across pauses.
- R7: After the `sclk` edge that captures the 30th bit, `af_valid` goes high at the third rising `wclk` edge and `ae_valid` goes high at the third rising `rclk` edge.
- R8: After a stream completes, the position returns to the start. The next stream overwrites the empty offset starting again from bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial load clock |
| wclk | input | 1 | Write-side clock; times `af_valid` |
| rclk | input | 1 | Read-side clock; times `ae_valid` |
| rst_n | input | 1 | Synchronous active-low master reset, sampled in every domain |
| load_n | input | 1 | Active-low load select |
| sen_n | input | 1 | Active-low serial enable |
| sdata | input | 1 | Serial data bit |
| empty_ofs | output | 15 | Almost-empty threshold |
| full_ofs | output | 15 | Almost-full threshold |
| af_valid | output | 1 | Full offset usable (write-clock domain) |
| ae_valid | output | 1 | Empty offset usable (read-clock domain) |

## Verification
The cycle-level assertions cover the following on every serial edge: the offsets stay unchanged when loading is not enabled, the position holds while serial enable is high, the position stays inside the stream, the first bit drops the completion state, and the last bit wraps the position and sets completion. In each destination domain they also check that a rising validity output follows its synchronized completion. Only the bench scenarios show the following: the exact three-edge latency of each validity output, that bits land in the right register positions, that loading resumes after mixed pauses on either control line, and that a second stream overwrites a completed load.

// File: rtl/sol_pkg.sv
// Shared definitions for the serial offset loader.
// Assumes nothing beyond a standard SystemVerilog compile order (this file first).
package sol_pkg;

    // Which threshold register a stream segment feeds; the order is the stream order.
    typedef enum logic {
        OFS_EMPTY = 1'b0,
        OFS_FULL  = 1'b1
    } ofs_kind_e;

    // Smallest latency the synchronizer-plus-counter stage can produce.
    localparam int SOL_MIN_LAT = 3;

    // Start index of a register's segment inside the serial stream.
    function automatic int seg_base(input ofs_kind_e kind, input int width);
        return (kind == OFS_FULL) ? width : 0;
    endfunction

endpackage

// File: rtl/sol_seq.sv
// Stream position tracker for the serial offset loader.
// Decides on each serial edge whether a bit is captured. It holds the position
// inside the stream and keeps a completion level that is high once the whole
// stream is loaded and low while a stream is in progress.
// Assumes: rst_n is synchronous to sclk and is held across at least one edge.
module sol_seq #(
    parameter int SEQ_LEN = 30,
    localparam int PW = (SEQ_LEN > 1) ? $clog2(SEQ_LEN) : 1
) (
    input  logic          sclk,
    input  logic          rst_n,
    input  logic          load_n,
    input  logic          sen_n,
    output logic          capture,
    output logic [PW-1:0] pos,
    output logic          done
);

    localparam logic [PW-1:0] LAST = PW'(SEQ_LEN - 1);

    // A bit is taken only when both active-low controls are asserted.
    assign capture = ~load_n & ~sen_n;

    // Advance the position on every capture and wrap after the last bit.
    always_ff @(posedge sclk) begin
        if (!rst_n) begin
            pos <= '0;
        end else if (capture) begin
            pos <= (pos == LAST) ? '0 : pos + PW'(1);
        end
    end

    // Completion goes low with any non-final bit and high with the final bit.
    always_ff @(posedge sclk) begin
        if (!rst_n) begin
            done <= 1'b1;
        end else if (capture) begin
            done <= (pos == LAST);
        end
    end

endmodule

// File: rtl/sol_ofs_reg.sv
// One threshold register loaded from its segment of the serial stream.
// Bit i of the register takes sdata when the stream position equals BASE+i.
// Assumes: pos never exceeds the stream length (guaranteed by sol_seq).
module sol_ofs_reg #(
    parameter int          W       = 15,
    parameter int          BASE    = 0,
    parameter int          PW      = 5,
    parameter logic [W-1:0] DEF_VAL = W'(7)
) (
    input  logic          sclk,
    input  logic          rst_n,
    input  logic          capture,
    input  logic [PW-1:0] pos,
    input  logic          sdata,
    output logic [W-1:0]  value
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        localparam logic [PW-1:0] IDX = PW'(BASE + i);

        // Load this bit from the stream when its position comes up.
        always_ff @(posedge sclk) begin
            if (!rst_n) begin
                value[i] <= DEF_VAL[i];
            end else if (capture && (pos == IDX)) begin
                value[i] <= sdata;
            end
        end
    end

endmodule

// File: rtl/sol_valid_sync.sv
// Moves the serial-domain completion level into one destination clock domain
// and raises a validity output LAT rising edges after completion is set.
// A two-flop synchronizer is followed by a small hold counter.
// Assumes: LAT >= 3; done_in is a level that changes at most once per stream.
module sol_valid_sync #(
    parameter int LAT = 3,
    localparam int HOLD = LAT - 3,
    localparam int CW = (HOLD > 0) ? $clog2(HOLD + 1) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic done_in,
    output logic synced,
    output logic valid
);

    localparam logic [CW-1:0] HOLD_V = CW'(HOLD);

    logic [1:0]    sync_q;
    logic [CW-1:0] cnt;

    // Two-stage synchronizer for the completion level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= 2'b00;
        end else begin
            sync_q <= {sync_q[0], done_in};
        end
    end

    assign synced = sync_q[1];

    // Count extra edges past the synchronizer, then raise validity.
    always_ff @(posedge clk) begin
        if (!rst_n || !synced) begin
            cnt   <= '0;
            valid <= 1'b0;
        end else begin
            if (cnt != HOLD_V) begin
                cnt <= cnt + CW'(1);
            end
            valid <= (cnt == HOLD_V);
        end
    end

endmodule

// File: rtl/serial_offset_loader.sv
// Serial loader for the almost-empty and almost-full FIFO thresholds.
// One continuous stream fills the empty offset and then the full offset, each
// LSB first. Validity is raised per consumer clock domain after a fixed delay.
// Assumes: rst_n is held low across edges of all three clocks; the read and write
// clocks need no fixed relation to sclk.
module serial_offset_loader #(
    parameter int              OFS_W     = 15,
    parameter logic [OFS_W-1:0] DEF_EMPTY = OFS_W'(7),
    parameter logic [OFS_W-1:0] DEF_FULL  = OFS_W'(7),
    parameter int              VALID_LAT = 3
) (
    input  logic             sclk,
    input  logic             wclk,
    input  logic             rclk,
    input  logic             rst_n,
    input  logic             load_n,
    input  logic             sen_n,
    input  logic             sdata,
    output logic [OFS_W-1:0] empty_ofs,
    output logic [OFS_W-1:0] full_ofs,
    output logic             af_valid,
    output logic             ae_valid
);
    import sol_pkg::*;

    localparam int SEQ_LEN = 2 * OFS_W;
    localparam int PW      = (SEQ_LEN > 1) ? $clog2(SEQ_LEN) : 1;
    localparam int NDOM    = 2;

    logic          capture;
    logic [PW-1:0] bit_pos;
    logic          prog_done;

    // Stream position and completion state.
    sol_seq #(.SEQ_LEN(SEQ_LEN)) u_seq (
        .sclk    (sclk),
        .rst_n   (rst_n),
        .load_n  (load_n),
        .sen_n   (sen_n),
        .capture (capture),
        .pos     (bit_pos),
        .done    (prog_done)
    );

    // Empty offset: first segment of the stream.
    sol_ofs_reg #(
        .W(OFS_W), .BASE(seg_base(OFS_EMPTY, OFS_W)), .PW(PW), .DEF_VAL(DEF_EMPTY)
    ) u_empty (
        .sclk    (sclk),
        .rst_n   (rst_n),
        .capture (capture),
        .pos     (bit_pos),
        .sdata   (sdata),
        .value   (empty_ofs)
    );

    // Full offset: second segment of the stream.
    sol_ofs_reg #(
        .W(OFS_W), .BASE(seg_base(OFS_FULL, OFS_W)), .PW(PW), .DEF_VAL(DEF_FULL)
    ) u_full (
        .sclk    (sclk),
        .rst_n   (rst_n),
        .capture (capture),
        .pos     (bit_pos),
        .sdata   (sdata),
        .value   (full_ofs)
    );

    // Domain 0 is the write clock (almost-full), domain 1 the read clock (almost-empty).
    logic [NDOM-1:0] dom_clk;
    logic [NDOM-1:0] dom_synced;
    logic [NDOM-1:0] dom_valid;

    assign dom_clk = {rclk, wclk};

    for (genvar d = 0; d < NDOM; d++) begin : g_dom
        sol_valid_sync #(.LAT(VALID_LAT)) u_vs (
            .clk     (dom_clk[d]),
            .rst_n   (rst_n),
            .done_in (prog_done),
            .synced  (dom_synced[d]),
            .valid   (dom_valid[d])
        );
    end

    assign af_valid = dom_valid[0];
    assign ae_valid = dom_valid[1];

endmodule

// File: rtl/sol_checker.sv
// Cycle-level properties of the serial offset loader, bound to the top module.
// Assumes the bound top exposes bit_pos, capture, prog_done and dom_synced.
module sol_checker #(
    parameter int              OFS_W     = 15,
    parameter logic [OFS_W-1:0] DEF_EMPTY = OFS_W'(7),
    parameter logic [OFS_W-1:0] DEF_FULL  = OFS_W'(7),
    parameter int              PW        = 5
) (
    input logic             sclk,
    input logic             wclk,
    input logic             rclk,
    input logic             rst_n,
    input logic             load_n,
    input logic             sen_n,
    input logic [OFS_W-1:0] empty_ofs,
    input logic [OFS_W-1:0] full_ofs,
    input logic             af_valid,
    input logic             ae_valid,
    input logic             capture,
    input logic [PW-1:0]    bit_pos,
    input logic             prog_done,
    input logic [1:0]       dom_synced
);

    localparam int SEQ_LEN = 2 * OFS_W;
    localparam logic [PW-1:0] LAST = PW'(SEQ_LEN - 1);

    // R1
    defaults_after_reset_chk: assert property (@(posedge sclk) disable iff (!rst_n)
        $rose(rst_n) |-> (empty_ofs == DEF_EMPTY && full_ofs == DEF_FULL));

    // R2
    hold_unless_enabled_chk: assert property (@(posedge sclk) disable iff (!rst_n)
        (load_n || sen_n) |=> ($stable(empty_ofs) && $stable(full_ofs)));

    // R3
    pos_in_range_chk: assert property (@(posedge sclk) disable iff (!rst_n)
        bit_pos <= LAST);

    // R4
    pos_held_chk: assert property (@(posedge sclk) disable iff (!rst_n)
        (!load_n && sen_n) |=> $stable(bit_pos));

    // R6
    start_drops_done_chk: assert property (@(posedge sclk) disable iff (!rst_n)
        (capture && bit_pos == '0) |=> !prog_done);

    // R8
    wrap_sets_done_chk: assert property (@(posedge sclk) disable iff (!rst_n)
        (capture && bit_pos == LAST) |=> (bit_pos == '0 && prog_done));

    // R7
    af_rise_follows_sync_chk: assert property (@(posedge wclk) disable iff (!rst_n)
        $rose(af_valid) |-> $past(dom_synced[0]));

    // R7
    ae_rise_follows_sync_chk: assert property (@(posedge rclk) disable iff (!rst_n)
        $rose(ae_valid) |-> $past(dom_synced[1]));

endmodule

bind serial_offset_loader sol_checker #(
    .OFS_W(OFS_W), .DEF_EMPTY(DEF_EMPTY), .DEF_FULL(DEF_FULL), .PW(PW)
) u_chk (
    .sclk       (sclk),
    .wclk       (wclk),
    .rclk       (rclk),
    .rst_n      (rst_n),
    .load_n     (load_n),
    .sen_n      (sen_n),
    .empty_ofs  (empty_ofs),
    .full_ofs   (full_ofs),
    .af_valid   (af_valid),
    .ae_valid   (ae_valid),
    .capture    (capture),
    .bit_pos    (bit_pos),
    .prog_done  (prog_done),
    .dom_synced (dom_synced)
);

// File: tb/serial_offset_loader_tb.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver task predicts the port state after each edge and
// queues it; the monitor pops one item per edge and compares it with the ports.
module serial_offset_loader_tb;

    localparam int W = 15;
    localparam int N = 2 * W;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         load_n = 1'b1;
    logic         sen_n = 1'b1;
    logic         sdata = 1'b0;
    logic [W-1:0] empty_ofs;
    logic [W-1:0] full_ofs;
    logic         af_valid;
    logic         ae_valid;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [W-1:0] e;
        logic [W-1:0] f;
        logic         af;
        logic         ae;
        string        tag;
    } exp_t;

    exp_t sb_q[$];

    // Reference model state (from the requirements)
    logic [W-1:0] m_e, m_f;
    int           m_pos;
    logic         m_done, m_p1, m_p2, m_v;

    always #2.5 clk = ~clk;

    serial_offset_loader u_dut (
        .sclk(clk), .wclk(clk), .rclk(clk), .rst_n(rst_n),
        .load_n(load_n), .sen_n(sen_n), .sdata(sdata),
        .empty_ofs(empty_ofs), .full_ofs(full_ofs),
        .af_valid(af_valid), .ae_valid(ae_valid)
    );

    // Drive one cycle at the falling edge and queue the prediction for the next rising edge.
    task automatic step(input logic rst, input logic ld, input logic se, input logic b,
                        input string tag);
        exp_t it;
        @(negedge clk);
        rst_n = rst; load_n = ld; sen_n = se; sdata = b;
        if (!rst) begin
            m_e = 15'd7; m_f = 15'd7; m_pos = 0; m_done = 1'b1;
            m_p1 = 1'b0; m_p2 = 1'b0; m_v = 1'b0;
        end else begin
            // three-edge validity latency (R7, R6)
            m_v = m_p2; m_p2 = m_p1; m_p1 = m_done;
            if (!ld && !se) begin
                if (m_pos < W) m_e[m_pos] = b; else m_f[m_pos - W] = b;
                m_done = (m_pos == N - 1);
                m_pos  = (m_pos == N - 1) ? 0 : m_pos + 1;
            end
        end
        it.e = m_e; it.f = m_f; it.af = m_v; it.ae = m_v; it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic send_bits(input logic [W-1:0] e, input logic [W-1:0] f,
                             input int from, input int upto, input string tag);
        for (int k = from; k < upto; k++) begin
            step(1'b1, 1'b0, 1'b0, (k < W) ? e[k] : f[k - W], tag);
        end
    endtask

    task automatic idle(input int n, input string tag);
        for (int k = 0; k < n; k++) step(1'b1, 1'b1, 1'b1, 1'b0, tag);
    endtask

    // Monitor: compare ports against the queued prediction away from the edge.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb_q.size() > 0) begin
                exp_t it;
                it = sb_q.pop_front();
                checks++;
                if (empty_ofs !== it.e || full_ofs !== it.f ||
                    af_valid !== it.af || ae_valid !== it.ae) begin
                    errors++;
                    $display("FAIL %s: actual e=%h f=%h af=%b ae=%b expected e=%h f=%h af=%b ae=%b",
                             it.tag, empty_ofs, full_ofs, af_valid, ae_valid,
                             it.e, it.f, it.af, it.ae);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL all: watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R1: reset defaults, then validity after three edges
        for (int k = 0; k < 3; k++) step(1'b0, 1'b1, 1'b1, 1'b0, "R1");
        idle(4, "R1");

        // R3 R6 R7: full stream, validity drops and returns
        send_bits(15'h2A5C, 15'h51E3, 0, 2, "R6");
        send_bits(15'h2A5C, 15'h51E3, 2, N, "R3");
        idle(4, "R7");

        // R2 R4 R5: paused stream with toggling data, then resume
        send_bits(15'h0F0F, 15'h7801, 0, 10, "R3");
        for (int k = 0; k < 3; k++) step(1'b1, 1'b0, 1'b1, k[0], "R4");
        for (int k = 0; k < 3; k++) step(1'b1, 1'b1, 1'b0, ~k[0], "R5");
        for (int k = 0; k < 2; k++) step(1'b1, 1'b1, 1'b1, 1'b1, "R2");
        send_bits(15'h0F0F, 15'h7801, 10, 20, "R5");
        step(1'b1, 1'b0, 1'b1, 1'b1, "R6");
        send_bits(15'h0F0F, 15'h7801, 20, N, "R6");
        idle(4, "R7");

        // R8: new stream restarts at empty bit 0
        send_bits(15'h1357, 15'h6AC0, 0, 5, "R8");
        send_bits(15'h1357, 15'h6AC0, 5, N, "R8");
        idle(4, "R7");

        repeat (2) @(posedge clk);
        #3;
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule